// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Feedback Divider

This block is the feedback divider of an integer-N channel synthesizer, modelled as synchronous logic running on the oscillator clock. A binary channel word gives the total division ratio. The block then emits one reference-rate pulse per divide cycle. Two counters surround a dual-modulus prescaler that divides by 32 or 33. The prescaler has two parts: a gated four-or-five core, followed by a three-bit stage that advances once per core cycle. The extra input period is inserted only in the last core cycle of a prescaler cycle, and only while the modulus-control line is high.

The channel word is read as unsigned binary. Its upper bits give the program count P (the word divided by 32) and its low five bits give the swallow count S (the word modulo 32). In each output cycle the first S prescaler cycles run at 33 and the remaining P − S run at 32, so the output period is 32·P + S oscillator clocks. A new word takes effect only when an output cycle ends. A word outside the legal window is first clamped to the nearest legal ratio. The window is 1330 to 1480 by default, which matches a 1 MHz reference and 1 MHz channel steps.

Top module: `psd_divider`

## Requirements
- R1: While `rst` is high, `div_out` and `pre_out` are low, and `mode` is high when the swallow count of the clamped channel word is nonzero.
- R2: For any legal channel word, consecutive `div_out` pulses are exactly 32·P + S clocks apart, where P = word / 32 and S = word mod 32.
- R3: Each prescaler cycle, measured between falling edges of `pre_out`, lasts 33 clocks when `mode` is high during it and 32 clocks when `mode` is low.
- R4: Each output cycle contains exactly P prescaler cycles, and `mode` is high for exactly S of them. Those S are the first S cycles after the output pulse.
- R5: `div_out` is high for exactly one clock, and only in the clock in which `pre_out` has just fallen.
- R6: A change of `chan` during an output cycle leaves the length of that cycle unchanged. The new ratio applies from the next cycle.
- R7: A channel word below RATIO_MIN acts as RATIO_MIN, and a word above RATIO_MAX acts as RATIO_MAX.
- R8: `mode` changes value only in the clock in which `pre_out` has just fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| chan | input | 11 | Channel word, total division ratio in unsigned binary |
| div_out | output | 1 | One-clock pulse at the end of each divide cycle |
| pre_out | output | 1 | Prescaler output, the top bit of the three-bit stage |
| mode | output | 1 | Modulus control: high selects divide-by-33 |

## Verification
The bench builds the divider with its default window of 1330 to 1480 and the fixed base modulus of 32. With these values every period is short enough that many of them fit in one run. The bench sweeps ratios across the whole window in steps of five. It adds the words with a swallow count of zero and of 31, and checks every prescaler cycle within each measured output cycle. It also tests words just outside the window and at the extremes of the word, as well as a word change in the middle of a cycle.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Structure of the prescaler: core of 4 (5 when stretched) times a 2**RIP_W stage.
    localparam int CORE_DIV  = 4;
    localparam int CORE_W    = 3;
    localparam int RIP_W     = 3;
    localparam int BASE_LOG2 = 2 + RIP_W;
    localparam int BASE      = 1 << BASE_LOG2;

    // Channel word layout.
    localparam int CH_W = 11;
    localparam int P_W  = CH_W - BASE_LOG2;
    localparam int S_W  = BASE_LOG2;

    typedef struct packed {
        logic [P_W-1:0] prog;
        logic [S_W-1:0] swal;
    } split_t;

    function automatic logic [CH_W-1:0] clamp_word(input logic [CH_W-1:0] w,
                                                   input int lo, input int hi);
        if (int'(w) < lo) return CH_W'(lo);
        if (int'(w) > hi) return CH_W'(hi);
        return w;
    endfunction

    function automatic split_t split_word(input logic [CH_W-1:0] w);
        split_t r;
        r.prog = w[CH_W-1:BASE_LOG2];
        r.swal = w[BASE_LOG2-1:0];
        return r;
    endfunction

endpackage

// File: rtl/psd_core45.sv
module psd_core45
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stretch,
    output logic tick
);
    localparam logic [CORE_W-1:0] LAST_SHORT = CORE_W'(CORE_DIV - 1);
    localparam logic [CORE_W-1:0] LAST_LONG  = CORE_W'(CORE_DIV);

    logic [CORE_W-1:0] phase;

    assign tick = (phase == (stretch ? LAST_LONG : LAST_SHORT));

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/psd_ripple8.sv
module psd_ripple8
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic msb,
    output logic at_last
);
    logic [RIP_W-1:0] cnt;

    assign msb     = cnt[RIP_W-1];
    assign at_last = &cnt;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl
    import psd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ps_tick,
    input  split_t next_split,
    output logic   mode,
    output logic   div_out
);
    logic [P_W-1:0] p_left;
    logic [S_W-1:0] s_left;
    logic           pulse_q;
    logic           final_tick;

    assign final_tick = ps_tick && (p_left <= P_W'(1));
    assign mode       = (s_left != '0);
    assign div_out    = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_left  <= next_split.prog;
            s_left  <= next_split.swal;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= final_tick;
            if (final_tick) begin
                p_left <= next_split.prog;
                s_left <= next_split.swal;
            end else if (ps_tick) begin
                p_left <= p_left - 1'b1;
                if (s_left != '0) s_left <= s_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter int RATIO_MIN = 1330,
    parameter int RATIO_MAX = 1480
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_W-1:0] chan,
    output logic            div_out,
    output logic            pre_out,
    output logic            mode
);
    logic   core_tick;
    logic   rip_last;
    logic   stretch;
    logic   ps_tick;
    split_t next_split;

    assign next_split = split_word(clamp_word(chan, RATIO_MIN, RATIO_MAX));
    assign stretch    = mode && rip_last;
    assign ps_tick    = core_tick && rip_last;

    psd_core45 u_core (
        .clk    (clk),
        .rst    (rst),
        .stretch(stretch),
        .tick   (core_tick)
    );

    psd_ripple8 u_rip (
        .clk    (clk),
        .rst    (rst),
        .adv    (core_tick),
        .msb    (pre_out),
        .at_last(rip_last)
    );

    psd_swallow_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ps_tick   (ps_tick),
        .next_split(next_split),
        .mode      (mode),
        .div_out   (div_out)
    );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
    parameter int RATIO_MIN = 1330,
    parameter int RATIO_MAX = 1480
) (
    input logic clk,
    input logic rst,
    input logic div_out,
    input logic pre_out,
    input logic mode
);
    logic [11:0] gap;
    logic [6:0]  pgap;
    logic        seen_div;
    logic        seen_pre;
    logic        pre_fall;

    assign pre_fall = pre_q && !pre_out;
    logic pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            pgap     <= '0;
            seen_div <= 1'b0;
            seen_pre <= 1'b0;
            pre_q    <= 1'b0;
        end else begin
            pre_q <= pre_out;
            if (div_out) begin
                gap      <= 12'd1;
                seen_div <= 1'b1;
            end else if (gap != 12'hfff) begin
                gap <= gap + 1'b1;
            end
            if (pre_fall) begin
                pgap     <= 7'd1;
                seen_pre <= 1'b1;
            end else if (pgap != 7'h7f) begin
                pgap <= pgap + 1'b1;
            end
        end
    end

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    p_pulse_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        div_out |-> $fell(pre_out));

    p_mode_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> $fell(pre_out));

    p_period_range_r2: assert property (@(posedge clk) disable iff (rst)
        (div_out && seen_div) |-> (int'(gap) >= RATIO_MIN && int'(gap) <= RATIO_MAX));

    p_presc_len_r3: assert property (@(posedge clk) disable iff (rst)
        (pre_fall && seen_pre) |-> (pgap == 7'd32 || pgap == 7'd33));

endmodule

bind psd_divider psd_divider_chk #(
    .RATIO_MIN(RATIO_MIN),
    .RATIO_MAX(RATIO_MAX)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .div_out(div_out),
    .pre_out(pre_out),
    .mode   (mode)
);

// File: tb/psd_divider_test.sv
`timescale 1ns/1ps
module psd_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] chan = 11'd1330;
    logic        div_out, pre_out, mode;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    psd_divider uut (
        .clk    (clk),
        .rst    (rst),
        .chan   (chan),
        .div_out(div_out),
        .pre_out(pre_out),
        .mode   (mode)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leaves the bench at a falling clock edge where div_out is high.
    task automatic wait_pulse();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 4000);
        if (n >= 4000) check("R2 pulse timeout", n, 0);
    endtask

    // Measures one output cycle from the current pulse to the next one.
    task automatic measure(input int ratio, input string tag,
                           input int swap_at, input logic [10:0] swap_word);
        int   cnt = 0, since = 0, falls = 0, hi = 0, bad = 0;
        logic pm = mode;
        logic pp = pre_out;
        bit   done = 0;
        while (!done) begin
            @(negedge clk);
            cnt++;
            since++;
            if (cnt == swap_at) chan = swap_word;
            if (pp && !pre_out) begin
                falls++;
                if (pm) hi++;
                if (since != (pm ? 33 : 32)) bad++;
                since = 0;
            end
            pp = pre_out;
            pm = mode;
            if (div_out || cnt > 4000) done = 1;
        end
        check({"R2 period ", tag}, cnt, ratio);
        check({"R3 prescaler cycle length errors ", tag}, bad, 0);
        check({"R4 prescaler cycles per output ", tag}, falls, ratio / 32);
        check({"R4 swallowed cycles ", tag}, hi, ratio % 32);
    endtask

    task automatic run_word(input int word, input int ratio, input string tag);
        chan = 11'(word);
        wait_pulse();   // old cycle ends, new word taken here
        measure(ratio, tag, 0, 11'd0);
    endtask

    initial begin
        #(4 * 190000);
        check("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state, 1330 has swallow count 18
        check("R1 div_out in reset", int'(div_out), 0);
        check("R1 pre_out in reset", int'(pre_out), 0);
        check("R1 mode in reset", int'(mode), 1);
        rst = 1'b0;

        wait_pulse();
        for (int r = 1330; r <= 1480; r += 5) run_word(r, r, $sformatf("word %0d", r));
        run_word(1344, 1344, "S=0");
        run_word(1375, 1375, "S=31");
        run_word(1407, 1407, "S=31 P=43");

        // R7: clamping of out-of-window words
        run_word(0, 1330, "R7 zero");
        run_word(1329, 1330, "R7 below");
        run_word(1481, 1480, "R7 above");
        run_word(2047, 1480, "R7 top");

        // R6: word changed mid-cycle keeps the running period
        run_word(1330, 1330, "R6 setup");
        measure(1330, "R6 mid-cycle change", 100, 11'd1480);
        measure(1480, "R6 after change", 0, 11'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule